// File: doc/BRIEF.md
# Start-up and Run-time Watchdog with Initialization Lockout

This block supervises a processor from the moment reset is released. A 16-bit counter climbs by one on every tick of a selectable clock divider. Software keeps the system alive by pulsing a service strobe. Each service loads the counter's upper byte with a programmable 8-bit value and clears the lower byte, so the reload value and the divider together set the time left before expiry. If the counter passes its top value, the block raises an internal reset request. At the same time it drives an active-low reset pin so that external parts restart too.

The watchdog starts counting on its own after every reset. Software may switch it off early in boot by pulsing a disable strobe. Once the end-of-initialization strobe arrives, the off switch is locked and further disable strobes do nothing until the next reset. After an expiry, the reset request lasts a fixed number of cycles. The block then comes back exactly as it does after a reset: counting and unlocked.

Top module: `wdt_guard`

## Requirements
- R1: After reset release, `count_o` increases by exactly one on each divider tick while the watchdog is enabled. The asynchronous reset is released through a two-stage synchronizer, so counting starts on the third rising edge after `rst_ni` rises.
- R2: `div_sel_i` sets the number of clock cycles per tick: 00 gives 2, 01 gives 4, 10 gives 128 and 11 gives 256. The first increment after a reset release or a service comes that many cycles after it.
- R3: While `rst_ni` is low, `count_o` is 0, `wdt_rst_o` is 0 and `wdt_rst_pin_no` is 1.
- R4: A `disable_i` pulse stops the counter and the divider only if the lock is clear. A pulse on `init_done_i` sets the lock. A disable in the same cycle as `init_done_i` still takes effect. A disable after the lock is set has no effect.
- R5: A `service_i` pulse loads `count_o` with `{reload_i, 8'h00}` on the next edge and restarts the divider phase. This also happens while the watchdog is disabled.
- R6: A tick while `count_o` is 0xFFFF wraps the count to 0. On that same edge it raises `wdt_rst_o` high and drives `wdt_rst_pin_no` low.
- R7: The reset request lasts exactly 8 cycles. During those cycles the count stays at 0 and all strobes are ignored. Afterwards the watchdog is enabled and the lock is clear.
- R8: If a service and an expiring tick fall in the same cycle, the service wins: the count is reloaded and no reset request appears.
- R9: With divider 2 and reload 0xFF, expiry comes on the 512th edge after the service edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| service_i | input | 1 | Service strobe, one cycle per service |
| init_done_i | input | 1 | End-of-initialization strobe, sets the disable lock |
| disable_i | input | 1 | Request to stop the watchdog |
| reload_i | input | 8 | Value loaded into the counter's upper byte on service |
| div_sel_i | input | 2 | Divider select (2/4/128/256) |
| count_o | output | 16 | Current counter value |
| wdt_rst_o | output | 1 | Internal reset request, active high |
| wdt_rst_pin_no | output | 1 | External reset pin, active low |

## Verification
The hardest case to reach is a service strobe landing in exactly the cycle whose tick would overflow 0xFFFF. It needs a precise count of cycles from a known phase. The stimulus gets there by servicing with reload 0xFF at divider 2, waiting 511 cycles, and then pulsing service again. Long random runs with a high reload value and rare service strobes drive the block through natural expiries, with strobes scattered inside reset pulses. A cycle model in the bench compares every output in every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned CNT_W     = 16;
  localparam int unsigned REL_W     = 8;
  localparam int unsigned LOW_W     = CNT_W - REL_W;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned PH_W      = 8;
  localparam int unsigned PULSE_LEN = 8;
  localparam int unsigned PULSE_W   = $clog2(PULSE_LEN);

  typedef enum logic [SEL_W-1:0] {
    DIV_2   = 2'b00,
    DIV_4   = 2'b01,
    DIV_128 = 2'b10,
    DIV_256 = 2'b11
  } div_sel_e;

  // Last phase value before a tick for each divider setting
  function automatic logic [PH_W-1:0] phase_limit(input logic [SEL_W-1:0] sel);
    logic [PH_W-1:0] lim;
    case (div_sel_e'(sel))
      DIV_2:   lim = PH_W'(1);
      DIV_4:   lim = PH_W'(3);
      DIV_128: lim = PH_W'(127);
      default: lim = PH_W'(255);
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_no = stage_q[1];

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;
  logic            phase_en;
  logic            at_limit;

  always_comb begin
    at_limit = (phase_q == phase_limit(sel_i));
    tick_o   = run_i && at_limit;
    phase_en = restart_i || run_i;
    phase_d  = phase_q;
    if (restart_i || tick_o) begin
      phase_d = '0;
    end else if (run_i) begin
      phase_d = phase_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  // A tick clears the phase, so two ticks never come back to back
  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2

  // While stopped and not restarted, the phase holds
  AST_PHASE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(phase_q)); // R4

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [REL_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;
  logic             step;

  always_comb begin
    step     = run_i && tick_i && !load_i;
    expire_o = step && (count_q == CNT_MAX);
    count_en = clear_i || load_i || step;
    count_d  = count_q;
    if (clear_i) begin
      count_d = '0;
    end else if (load_i) begin
      count_d = {reload_i, {LOW_W{1'b0}}};
    end else if (step) begin
      count_d = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

  AST_SERVICE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i) |=> (count_q == {$past(reload_i), {LOW_W{1'b0}}})); // R5

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !clear_i && count_q != CNT_MAX) |=> (count_q == $past(count_q) + CNT_W'(1))); // R1

endmodule

// File: rtl/wdt_supervise.sv
module wdt_supervise
  import wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic disable_i,
  input  logic init_done_i,
  input  logic expire_i,
  output logic enabled_o,
  output logic locked_o,
  output logic pulse_o
);

  logic               en_q, en_d;
  logic               lock_q, lock_d;
  logic               pulse_q, pulse_d;
  logic [PULSE_W-1:0] pcnt_q, pcnt_d;
  logic               last_pulse;

  always_comb begin
    last_pulse = (pcnt_q == PULSE_W'(PULSE_LEN - 1));
    en_d    = en_q;
    lock_d  = lock_q;
    pulse_d = pulse_q;
    pcnt_d  = pcnt_q;
    if (pulse_q) begin
      en_d   = 1'b1;
      lock_d = 1'b0;
      if (last_pulse) begin
        pulse_d = 1'b0;
        pcnt_d  = '0;
      end else begin
        pcnt_d = pcnt_q + PULSE_W'(1);
      end
    end else if (expire_i) begin
      pulse_d = 1'b1;
      pcnt_d  = '0;
      en_d    = 1'b1;
      lock_d  = 1'b0;
    end else begin
      if (disable_i && !lock_q) begin
        en_d = 1'b0;
      end
      if (init_done_i) begin
        lock_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b1;
      lock_q  <= 1'b0;
      pulse_q <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      en_q    <= en_d;
      lock_q  <= lock_d;
      pulse_q <= pulse_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign enabled_o = en_q;
  assign locked_o  = lock_q;
  assign pulse_o   = pulse_q;

  AST_LOCK_KEEPS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && en_q && !pulse_q) |=> en_q); // R4

  AST_PULSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q && !last_pulse) |=> pulse_q); // R7

  AST_CLEAN_AFTER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_q) |-> (en_q && !lock_q)); // R7

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             service_i,
  input  logic             init_done_i,
  input  logic             disable_i,
  input  logic [REL_W-1:0] reload_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wdt_rst_o,
  output logic             wdt_rst_pin_no
);

  logic rst_int_n;
  logic enabled;
  logic locked;
  logic pulse;
  logic run;
  logic svc_eff;
  logic tick;
  logic expire;

  wdt_rst_sync u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  always_comb begin
    run     = enabled && !pulse;
    svc_eff = service_i && !pulse;
  end

  wdt_prescale u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .run_i     (run),
    .restart_i (svc_eff || pulse),
    .sel_i     (div_sel_i),
    .tick_o    (tick)
  );

  wdt_counter u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .run_i    (run),
    .tick_i   (tick),
    .load_i   (svc_eff),
    .clear_i  (pulse),
    .reload_i (reload_i),
    .count_o  (count_o),
    .expire_o (expire)
  );

  wdt_supervise u_sup (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .disable_i   (disable_i && !pulse),
    .init_done_i (init_done_i && !pulse),
    .expire_i    (expire),
    .enabled_o   (enabled),
    .locked_o    (locked),
    .pulse_o     (pulse)
  );

  assign wdt_rst_o      = pulse;
  assign wdt_rst_pin_no = !pulse;

  AST_EXPIRE_FIRES: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    expire |=> (wdt_rst_o && !wdt_rst_pin_no && count_o == '0)); // R6

  AST_SERVICE_WINS: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (svc_eff && tick && count_o == {CNT_W{1'b1}}) |=> !wdt_rst_o); // R8

  AST_NO_EXPIRE_UNLOCKED_OFF: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (!enabled && !pulse) |-> !expire); // R4

  AST_DISABLE_BEFORE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (disable_i && !locked && !pulse && !expire) |=> !enabled); // R4

endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        svc, einit, dis;
  logic [7:0]  reload;
  logic [1:0]  sel;
  logic [15:0] count;
  logic        irst, pin_n;

  int vectors = 0;
  int fails   = 0;

  // model state
  bit m_s1, m_s2, m_en, m_lock, m_pulse;
  int m_pcnt, m_ph, m_cnt;

  always #4 clk = ~clk;

  wdt_guard uut (
    .clk_i(clk), .rst_ni(rst_ni), .service_i(svc), .init_done_i(einit),
    .disable_i(dis), .reload_i(reload), .div_sel_i(sel),
    .count_o(count), .wdt_rst_o(irst), .wdt_rst_pin_no(pin_n)
  );

  function automatic int div_of(input logic [1:0] s);
    case (s)
      2'b00:   return 2;
      2'b01:   return 4;
      2'b10:   return 128;
      default: return 256;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_en = 1; m_lock = 0; m_pulse = 0;
    m_pcnt = 0; m_ph = 0; m_cnt = 0;
  endtask

  // state after the coming rising edge, from the requirements
  task automatic model_step();
    bit run_state, svc_e, tick;
    if (!rst_ni) begin model_reset(); return; end
    run_state = m_s2;
    m_s2 = m_s1; m_s1 = 1;
    if (!run_state) return;
    svc_e = svc && !m_pulse;
    if (m_pulse) begin
      m_cnt = 0; m_ph = 0;
      if (m_pcnt == 7) begin m_pulse = 0; m_pcnt = 0; end
      else m_pcnt++;
      return;
    end
    tick = m_en && (m_ph == div_of(sel) - 1);
    if (svc_e) begin
      m_cnt = {reload, 8'h00}; m_ph = 0;
    end else if (m_en) begin
      if (tick) begin
        m_ph = 0;
        if (m_cnt == 16'hFFFF) begin
          m_cnt = 0; m_pulse = 1; m_pcnt = 0; m_en = 1; m_lock = 0;
          return;
        end
        m_cnt++;
      end else begin
        m_ph = (m_ph + 1) & 255;
      end
    end
    if (dis && !m_lock) m_en = 0;
    if (einit) m_lock = 1;
  endtask

  // one clock: model advances, then outputs compared at the falling edge
  task automatic cyc();
    model_step();
    @(negedge clk);
    check("R1 count", count, m_cnt);
    check("R6 request", irst, m_pulse);
    check("R6 pin", pin_n, !m_pulse);
  endtask

  task automatic idle();
    svc = 0; einit = 0; dis = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 0; model_reset();
    @(negedge clk);
    check("R3 count in reset", count, 0);
    check("R3 request in reset", irst, 0);
    check("R3 pin in reset", pin_n, 1);
    rst_ni = 1;
    repeat (3) cyc();
  endtask

  task automatic pulse_svc(input logic [7:0] r);
    reload = r; svc = 1; cyc(); svc = 0;
  endtask

  task automatic main_seq();
    int base;
    reload = 0; sel = 0; idle();
    rst_ni = 0; model_reset();
    repeat (2) @(negedge clk);
    do_reset();

    // R3 / R1: running by itself; count grows
    base = count;
    repeat (10) cyc();
    check("R1 count advanced by 5", count, base + 5);

    // R2: spacing for each divider
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      pulse_svc(8'hFF);
      repeat (div_of(sel) - 1) cyc();
      check("R2 before tick", count, 16'hFF00);
      cyc();
      check("R2 first tick", count, 16'hFF01);
    end

    // R9 / R6 / R7: expiry timing and pulse length; lock set beforehand
    sel = 0;
    einit = 1; cyc(); einit = 0;
    pulse_svc(8'hFF);
    check("R5 loaded", count, 16'hFF00);
    repeat (510) cyc();
    check("R9 reached top", count, 16'hFFFF);
    cyc();
    check("R9 no expiry yet", irst, 0);
    cyc();
    check("R6 expiry request", irst, 1);
    check("R6 pin low", pin_n, 0);
    check("R6 count wrapped", count, 0);
    svc = 1; dis = 1; reload = 8'h55;
    repeat (7) cyc();
    idle();
    check("R7 strobes ignored, count 0", count, 0);
    check("R7 request still high", irst, 1);
    cyc();
    check("R7 request ends after 8", irst, 0);
    // lock cleared by expiry: disable works now
    dis = 1; cyc(); dis = 0;
    base = count;
    repeat (40) cyc();
    check("R7 lock cleared, disable works", count, base);

    // R5 service while disabled still loads
    pulse_svc(8'h3C);
    repeat (5) cyc();
    check("R5 load while off", count, 16'h3C00);

    // R8: service on the expiring cycle
    do_reset();
    sel = 0;
    pulse_svc(8'hFF);
    repeat (511) cyc();
    check("R8 at top", count, 16'hFFFF);
    pulse_svc(8'h12);
    check("R8 service wins count", count, 16'h1200);
    check("R8 no request", irst, 0);
    repeat (3) cyc();
    check("R8 still no request", irst, 0);

    // R4: disable together with end-of-init still stops
    do_reset();
    dis = 1; einit = 1; cyc(); idle();
    base = count;
    repeat (30) cyc();
    check("R4 same-cycle disable", count, base);

    // R4: disable after lock ignored
    do_reset();
    einit = 1; cyc(); einit = 0;
    dis = 1; cyc(); dis = 0;
    base = count;
    repeat (20) cyc();
    check("R4 disable ignored after lock", count, base + 10);

    // random phase
    do_reset();
    for (int i = 0; i < 30000; i++) begin
      svc    = ($urandom % 700) == 0;
      dis    = ($urandom % 4000) == 0;
      einit  = ($urandom % 1500) == 0;
      reload = 8'hE0 | 8'($urandom % 32);
      if (($urandom % 3000) == 0) sel = 2'($urandom % 4);
      if (($urandom % 12000) == 0) do_reset();
      else cyc();
    end
    idle();
  endtask

  initial begin
    void'($urandom(32'd4417));
    fork
      main_seq();
      begin
        repeat (190000) @(posedge clk);
        fails++; vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule